// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy and Fill Engine

This block moves a rectangle of bytes from one place in a framebuffer to another, or paints a rectangle with one constant byte. Software sets it up through a small word-addressed register file. It writes the source and destination corners, the rectangle size, the two row pitches, the two base addresses and the fill colour. It then writes a command word with the go bit set. The engine computes every byte address as base times eight, plus row times pitch, plus column. It reads each source byte and then writes it to the destination. In fill mode it only writes.

The engine does not keep any ordering knowledge of its own. When the source lies above the destination, or on the same row to its left, software selects reverse traversal. It then supplies the bottom-right corners, and the engine walks from the last byte of the last row back to the first byte of the first row. With that choice, overlapping copies never read a byte that has already been overwritten. Software polls a busy bit until it clears.

Memory traffic uses one request channel with valid/ready. Once the engine raises `mem_req_valid`, it holds the address, direction and write data unchanged until `mem_req_ready` is seen high on a clock edge. Read data comes back on `mem_rsp_valid`/`mem_rsp_data`, and that channel has no back-pressure. The engine has one access outstanding at most.

Top module: `blit_engine`

## Requirements
- R1: After reset, every register reads as zero, the busy bit reads 0 and no memory request is raised.
- R2: Register word addresses are 0 source corner, 1 destination corner, 2 size, 3 command, 4 pitches, 5 fill colour, 6 source base, 7 destination base, 8 status. In a corner, x sits in bits 31:16 and y in bits 15:0. In the size register, the width in bytes sits in bits 31:16 and the height in lines in bits 15:0. In the pitch register, the destination pitch sits in bits 31:16 and the source pitch in bits 15:0. Written registers read back unchanged.
- R3: Each byte address equals base*8 + row*pitch + column, using the base and pitch of the side being accessed.
- R4: In forward mode (command bit 27 clear), rows go from top to bottom and bytes from left to right. Each byte is read from the source and then written to the destination with the value read, so width*height reads and writes take place.
- R5: In reverse mode (command bit 27 set), the given corners are the bottom-right ones. Column and row both decrement, and the operation ends once the top-left byte has been written. An overlapping copy therefore leaves the destination equal to the original source contents.
- R6: In fill mode (command bit 16 set), bits 7:0 of the colour register are written to every destination byte, and no read is issued.
- R7: A command write with bit 31 set starts the operation. Status bit 0 reads 1 from the next cycle until the last write is accepted.
- R8: A start command written while busy is ignored: no extra accesses occur and the running operation completes unchanged.
- R9: A start with zero width or zero height performs no memory access and leaves busy at 0.
- R10: A raised request stays raised, with address, direction and data stable, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |

## Verification
The assertions assume that the memory returns exactly one response for each accepted read. That response must arrive on the cycle after the read was accepted, and no response may arrive otherwise. The bench memory model produces `mem_rsp_valid` only as a registered copy of a read handshake, so it stays within that assumption. The bench also lowers `mem_req_ready` in a repeating pattern, so request stalls occur during every operation. All rectangles are chosen so that their addresses stay inside the modelled memory, which keeps the address arithmetic free of wrap-around.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int CW     = 16;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_SRC_XY   = 4'd0;
  localparam logic [REG_AW-1:0] RA_DST_XY   = 4'd1;
  localparam logic [REG_AW-1:0] RA_SIZE     = 4'd2;
  localparam logic [REG_AW-1:0] RA_CMD      = 4'd3;
  localparam logic [REG_AW-1:0] RA_PITCH    = 4'd4;
  localparam logic [REG_AW-1:0] RA_FG       = 4'd5;
  localparam logic [REG_AW-1:0] RA_SRC_BASE = 4'd6;
  localparam logic [REG_AW-1:0] RA_DST_BASE = 4'd7;
  localparam logic [REG_AW-1:0] RA_STATUS   = 4'd8;

  localparam int CB_GO   = 31;
  localparam int CB_REV  = 27;
  localparam int CB_FILL = 16;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} seq_state_t;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  output logic [31:0]       rdata,
  output logic              start,
  output logic              start_rev,
  output logic              start_fill,
  output logic [CW-1:0]     src_x,
  output logic [CW-1:0]     src_y,
  output logic [CW-1:0]     dst_x,
  output logic [CW-1:0]     dst_y,
  output logic [CW-1:0]     size_w,
  output logic [CW-1:0]     size_h,
  output logic [CW-1:0]     src_pitch,
  output logic [CW-1:0]     dst_pitch,
  output logic [7:0]        fg_byte,
  output logic [BASE_W-1:0] src_base,
  output logic [BASE_W-1:0] dst_base
);
  localparam logic [31:0] CMD_KEEP = (32'd1 << CB_REV) | (32'd1 << CB_FILL);

  logic [31:0] src_xy_q, dst_xy_q, size_q, pitch_q, fg_q, cmd_q;
  logic [BASE_W-1:0] sb_q, db_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_xy_q <= '0;
      dst_xy_q <= '0;
      size_q   <= '0;
      pitch_q  <= '0;
      fg_q     <= '0;
      cmd_q    <= '0;
      sb_q     <= '0;
      db_q     <= '0;
    end else if (we) begin
      case (addr)
        RA_SRC_XY:   src_xy_q <= wdata;
        RA_DST_XY:   dst_xy_q <= wdata;
        RA_SIZE:     size_q   <= wdata;
        RA_CMD:      cmd_q    <= wdata & CMD_KEEP;
        RA_PITCH:    pitch_q  <= wdata;
        RA_FG:       fg_q     <= wdata;
        RA_SRC_BASE: sb_q     <= wdata[BASE_W-1:0];
        RA_DST_BASE: db_q     <= wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  assign start      = we && (addr == RA_CMD) && wdata[CB_GO] && !busy;
  assign start_rev  = wdata[CB_REV];
  assign start_fill = wdata[CB_FILL];

  assign src_x     = src_xy_q[31:16];
  assign src_y     = src_xy_q[15:0];
  assign dst_x     = dst_xy_q[31:16];
  assign dst_y     = dst_xy_q[15:0];
  assign size_w    = size_q[31:16];
  assign size_h    = size_q[15:0];
  assign dst_pitch = pitch_q[31:16];
  assign src_pitch = pitch_q[15:0];
  assign fg_byte   = fg_q[7:0];
  assign src_base  = sb_q;
  assign dst_base  = db_q;

  always_comb begin
    case (addr)
      RA_SRC_XY:   rdata = src_xy_q;
      RA_DST_XY:   rdata = dst_xy_q;
      RA_SIZE:     rdata = size_q;
      RA_CMD:      rdata = cmd_q;
      RA_PITCH:    rdata = pitch_q;
      RA_FG:       rdata = fg_q;
      RA_SRC_BASE: rdata = 32'(sb_q);
      RA_DST_BASE: rdata = 32'(db_q);
      RA_STATUS:   rdata = {31'd0, busy};
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              backward,
  input  logic [BASE_W-1:0] base,
  input  logic [CW-1:0]     x,
  input  logic [CW-1:0]     y,
  input  logic [CW-1:0]     pitch,
  input  logic              row_step,
  input  logic [CW-1:0]     col,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] pitch_q;
  logic              rev_q;
  logic [31:0]       row_prod;
  logic [ADDR_W-1:0] first_addr;

  assign row_prod   = 32'(y) * 32'(pitch);
  assign first_addr = ADDR_W'({base, 3'b000}) + ADDR_W'(row_prod) + ADDR_W'(x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      pitch_q <= '0;
      rev_q   <= 1'b0;
    end else if (load) begin
      row_q   <= first_addr;
      pitch_q <= ADDR_W'(pitch);
      rev_q   <= backward;
    end else if (row_step) begin
      row_q <= rev_q ? row_q - pitch_q : row_q + pitch_q;
    end
  end

  assign addr = rev_q ? row_q - ADDR_W'(col) : row_q + ADDR_W'(col);
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_fill,
  input  logic [CW-1:0] size_w,
  input  logic [CW-1:0] size_h,
  input  logic [7:0]    fg_byte,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [7:0]    mem_req_wdata,
  output logic          load,
  output logic          row_step,
  output logic [CW-1:0] col,
  output logic          busy
);
  seq_state_t  state_q;
  logic [CW-1:0] col_q, row_q, w_q, h_q;
  logic          fill_q;
  logic [7:0]    fg_q, data_q;
  logic          empty_rect, last_col, last_row, wr_done;
  seq_state_t    next_xfer;

  assign empty_rect = (size_w == '0) || (size_h == '0);
  assign last_col   = (col_q == w_q - CW'(1));
  assign last_row   = (row_q == h_q - CW'(1));
  assign wr_done    = (state_q == S_WR) && mem_req_ready;
  assign next_xfer  = fill_q ? S_WR : S_RD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      w_q     <= '0;
      h_q     <= '0;
      fill_q  <= 1'b0;
      fg_q    <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start && !empty_rect) begin
          col_q   <= '0;
          row_q   <= '0;
          w_q     <= size_w;
          h_q     <= size_h;
          fill_q  <= start_fill;
          fg_q    <= fg_byte;
          state_q <= start_fill ? S_WR : S_RD;
        end
        S_RD: if (mem_req_ready) state_q <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          data_q  <= mem_rsp_data;
          state_q <= S_WR;
        end
        S_WR: if (wr_done) begin
          if (last_col) begin
            if (last_row) begin
              state_q <= S_IDLE;
            end else begin
              col_q   <= '0;
              row_q   <= row_q + CW'(1);
              state_q <= next_xfer;
            end
          end else begin
            col_q   <= col_q + CW'(1);
            state_q <= next_xfer;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign load          = start;
  assign row_step      = wr_done && last_col && !last_row;
  assign col           = col_q;
  assign busy          = (state_q != S_IDLE);
  assign mem_req_valid = (state_q == S_RD) || (state_q == S_WR);
  assign mem_req_write = (state_q == S_WR);
  assign mem_req_wdata = fill_q ? fg_q : data_q;
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data
);
  localparam int NSIDE = 2;

  logic              busy, start, start_rev, start_fill, load, row_step;
  logic [CW-1:0]     src_x, src_y, dst_x, dst_y, size_w, size_h;
  logic [CW-1:0]     src_pitch, dst_pitch, col;
  logic [7:0]        fg_byte;
  logic [BASE_W-1:0] src_base, dst_base;

  logic [BASE_W-1:0] side_base  [NSIDE];
  logic [CW-1:0]     side_x     [NSIDE];
  logic [CW-1:0]     side_y     [NSIDE];
  logic [CW-1:0]     side_pitch [NSIDE];
  logic [ADDR_W-1:0] side_addr  [NSIDE];

  blit_regs #(.BASE_W(BASE_W)) u_regs (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .busy,
    .rdata(reg_rdata), .start, .start_rev, .start_fill,
    .src_x, .src_y, .dst_x, .dst_y, .size_w, .size_h,
    .src_pitch, .dst_pitch, .fg_byte, .src_base, .dst_base
  );

  blit_seq u_seq (
    .clk, .rst_n, .start, .start_fill, .size_w, .size_h, .fg_byte,
    .mem_req_ready, .mem_rsp_valid, .mem_rsp_data,
    .mem_req_valid, .mem_req_write, .mem_req_wdata,
    .load, .row_step, .col, .busy
  );

  // side 0 = source, side 1 = destination
  assign side_base[0]  = src_base;
  assign side_base[1]  = dst_base;
  assign side_x[0]     = src_x;
  assign side_x[1]     = dst_x;
  assign side_y[0]     = src_y;
  assign side_y[1]     = dst_y;
  assign side_pitch[0] = src_pitch;
  assign side_pitch[1] = dst_pitch;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    blit_addr_gen #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_ag (
      .clk, .rst_n, .load, .backward(start_rev),
      .base(side_base[g]), .x(side_x[g]), .y(side_y[g]), .pitch(side_pitch[g]),
      .row_step, .col, .addr(side_addr[g])
    );
  end

  assign mem_req_addr = mem_req_write ? side_addr[1] : side_addr[0];
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic [CW-1:0]     size_w,
  input logic [CW-1:0]     size_h,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r7_busy_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == RA_CMD && reg_wdata[CB_GO]));

  a_r4_read_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_write |=> !mem_req_valid);

  a_r9_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == RA_CMD && reg_wdata[CB_GO] && !busy
      && (size_w == '0 || size_h == '0) |=> !busy);
endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .size_w(size_w), .size_h(size_h),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/sim_blit_engine.sv
`timescale 1ns/1ps
module sim_blit_engine;
  import blit_pkg::*;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = '0;

  blit_engine #(.ADDR_W(AW)) u0 (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr,
    .mem_req_wdata, .mem_rsp_valid, .mem_rsp_data
  );

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [7:0] mem [0:4095];

  typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: initialised under reset, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 5 + 1);
      mem_rsp_valid <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready && mem_req_write)
        mem[mem_req_addr[11:0]] <= mem_req_wdata;
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
      mem_rsp_data  <= mem[mem_req_addr[11:0]];
    end
  end

  // back-pressure pattern, changed away from both edges
  int rc = 0;
  always @(posedge clk) begin
    #1;
    rc = rc + 1;
    mem_req_ready = (rc % 3) != 1;
  end

  // monitor: scoreboard pop and request-hold check
  logic held = 1'b0;
  logic [AW-1:0] held_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        chk(mem_req_valid && mem_req_addr == held_addr, "R10", "stalled request held",
            mem_req_addr, held_addr);
      end
      held = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          wr_cnt++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected write addr", mem_req_addr, 0);
          end else begin
            wr_item_t e;
            e = exp_q.pop_front();
            chk(mem_req_addr == e.a, "R3", "write address", mem_req_addr, e.a);
            chk(mem_req_wdata == e.d, "R4", "write data", mem_req_wdata, e.d);
          end
        end else begin
          rd_cnt++;
        end
      end
    end
  end

  task automatic reg_wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [REG_AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    v = 32'd1;
    while (v[0] && n < 4000) begin
      reg_rd(RA_STATUS, v);
      n++;
    end
    chk(!v[0], req, "busy clears", v[0], 0);
  endtask

  // program registers, push expected writes, then issue the command
  task automatic run_op(input int sx, sy, dx, dy, w, h, sp, dp, sb, db,
                        input bit rev, input bit fill, input logic [31:0] fg);
    reg_wr(RA_SRC_XY, {16'(sx), 16'(sy)});
    reg_wr(RA_DST_XY, {16'(dx), 16'(dy)});
    reg_wr(RA_SIZE, {16'(w), 16'(h)});
    reg_wr(RA_PITCH, {16'(dp), 16'(sp)});
    reg_wr(RA_FG, fg);
    reg_wr(RA_SRC_BASE, 32'(sb));
    reg_wr(RA_DST_BASE, 32'(db));
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        int sa, da;
        wr_item_t it;
        if (rev) begin
          sa = sb * 8 + (sy - r) * sp + sx - c;
          da = db * 8 + (dy - r) * dp + dx - c;
        end else begin
          sa = sb * 8 + (sy + r) * sp + sx + c;
          da = db * 8 + (dy + r) * dp + dx + c;
        end
        it.a = AW'(da);
        it.d = fill ? fg[7:0] : mem[sa];
        exp_q.push_back(it);
      end
    end
    reg_wr(RA_CMD, (32'd1 << CB_GO) | (32'(rev) << CB_REV) | (32'(fill) << CB_FILL));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rd0, wr0;
    logic [7:0] snap [0:15];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(RA_STATUS, v);  chk(v == 0, "R1", "status after reset", v, 0);
    reg_rd(RA_SRC_XY, v);  chk(v == 0, "R1", "corner after reset", v, 0);
    reg_rd(RA_PITCH, v);   chk(v == 0, "R1", "pitch after reset", v, 0);
    chk(!mem_req_valid, "R1", "no request after reset", mem_req_valid, 0);

    // R2 readback
    reg_wr(RA_SIZE, 32'h0007_0009);
    reg_rd(RA_SIZE, v); chk(v == 32'h0007_0009, "R2", "size readback", v, 32'h0007_0009);

    // R4 forward copy, distinct pitches (R2 pitch packing, R3 addressing)
    rd0 = rd_cnt;
    run_op(3, 2, 5, 1, 4, 3, 32, 40, 0, 64, 1'b0, 1'b0, 0);
    reg_rd(RA_STATUS, v); chk(v[0] == 1'b1, "R7", "busy after start", v, 1);
    wait_idle("R7");
    chk(exp_q.size() == 0, "R4", "all forward writes seen", exp_q.size(), 0);
    chk(rd_cnt - rd0 == 12, "R4", "forward read count", rd_cnt - rd0, 12);

    // R5 reverse, same row, destination to the right
    for (int c = 0; c < 6; c++) snap[c] = mem[16 * 8 + 3 * 32 + 2 + c];
    run_op(7, 4, 10, 4, 6, 2, 32, 32, 16, 16, 1'b1, 1'b0, 0);
    wait_idle("R5");
    chk(exp_q.size() == 0, "R5", "all reverse writes seen", exp_q.size(), 0);
    for (int c = 0; c < 6; c++)
      chk(mem[16 * 8 + 3 * 32 + 5 + c] == snap[c], "R5", "overlap row result",
          mem[16 * 8 + 3 * 32 + 5 + c], snap[c]);

    // R5 reverse, destination below source
    for (int r = 0; r < 4; r++) snap[r] = mem[16 * 8 + (2 + r) * 32 + 4];
    run_op(6, 5, 6, 7, 3, 4, 32, 32, 16, 16, 1'b1, 1'b0, 0);
    wait_idle("R5");
    chk(exp_q.size() == 0, "R5", "vertical reverse writes seen", exp_q.size(), 0);
    for (int r = 0; r < 4; r++)
      chk(mem[16 * 8 + (4 + r) * 32 + 4] == snap[r], "R5", "overlap column result",
          mem[16 * 8 + (4 + r) * 32 + 4], snap[r]);

    // R4 forward, destination above and right of source (overlap)
    for (int r = 0; r < 3; r++) snap[r] = mem[16 * 8 + (5 + r) * 32 + 1];
    run_op(1, 5, 3, 3, 5, 3, 32, 32, 16, 16, 1'b0, 1'b0, 0);
    wait_idle("R4");
    chk(exp_q.size() == 0, "R4", "upward forward writes seen", exp_q.size(), 0);
    for (int r = 0; r < 3; r++)
      chk(mem[16 * 8 + (3 + r) * 32 + 3] == snap[r], "R4", "upward overlap result",
          mem[16 * 8 + (3 + r) * 32 + 3], snap[r]);

    // R6 fill, only low colour byte, no reads
    rd0 = rd_cnt;
    run_op(0, 0, 2, 1, 7, 2, 0, 16, 0, 200, 1'b0, 1'b1, 32'h1234_565A);
    wait_idle("R6");
    chk(rd_cnt == rd0, "R6", "no reads during fill", rd_cnt - rd0, 0);
    chk(exp_q.size() == 0, "R6", "all fill writes seen", exp_q.size(), 0);

    // R8 start while busy is ignored
    wr0 = wr_cnt;
    rd0 = rd_cnt;
    run_op(0, 0, 0, 0, 20, 4, 0, 32, 0, 300, 1'b0, 1'b1, 32'h0000_00C3);
    reg_wr(RA_DST_XY, {16'd0, 16'd10});
    reg_wr(RA_CMD, (32'd1 << CB_GO) | (32'd1 << CB_FILL));
    reg_rd(RA_STATUS, v); chk(v[0] == 1'b1, "R8", "still busy after second go", v, 1);
    wait_idle("R8");
    chk(wr_cnt - wr0 == 80, "R8", "write count of first op only", wr_cnt - wr0, 80);
    chk(rd_cnt == rd0, "R8", "no reads from ignored start", rd_cnt - rd0, 0);
    chk(mem[300 * 8 + 10 * 32] != 8'hC3, "R8", "second region untouched",
        mem[300 * 8 + 10 * 32], 0);

    // R9 zero height does nothing
    wr0 = wr_cnt;
    rd0 = rd_cnt;
    reg_wr(RA_SIZE, {16'd4, 16'd0});
    reg_wr(RA_CMD, 32'd1 << CB_GO);
    reg_rd(RA_STATUS, v); chk(v[0] == 1'b0, "R9", "busy stays clear", v, 0);
    repeat (10) @(negedge clk);
    chk(wr_cnt == wr0 && rd_cnt == rd0, "R9", "no accesses", wr_cnt - wr0 + rd_cnt - rd0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule